// File: doc/BRIEF.md
# Interrupt Redirection Scan and Dispatch

This block turns a bank of interrupt input pins into delivery messages for processor cores. Each pin has a programmable redirection entry holding a delivery mode, a trigger-mode bit, a mask bit, an 8-bit vector and an 8-bit destination. There is also a remote-IRR status bit that the hardware keeps up. A loop counter visits one entry per clock. When the visited entry has an interrupt ready, the block emits a one-cycle message on the next clock. The message carries the pin index, vector, destination, delivery mode, effective trigger mode and a flag marking legacy-controller vectors.

Software programs an entry through a single-cycle write port. Level-triggered interrupts in fixed or lowest-priority mode are held off by remote-IRR until an end-of-interrupt with the matching vector arrives. NMI and INIT ignore a level programming. They behave as edge events and never set remote-IRR. While the pin is still high, an NMI or INIT entry programmed for level is sent again on every pass of the scan.

Top module: `redirScan`

## Requirements
- R1: After reset every entry is masked, the scan index is 0 and no message is issued, whatever the pins do.
- R2: The scan index moves up by one each clock and wraps from NPINS-1 to 0. A message for pin p appears on the clock after the scan visits p, and msgPin equals p.
- R3: An edge-class entry emits exactly one message per rising edge of its pin, however long the pin then stays high. The edge class covers trigger bit 0 in any usable mode, and also SMI and ExtINT whatever their trigger bit.
- R4: A level entry in fixed (000) or lowest-priority (001) mode with a high pin sends once and sets remote-IRR, which blocks further sends. An end-of-interrupt whose vector equals the entry's vector clears remote-IRR. The entry then sends again only if the pin is still high.
- R5: An end-of-interrupt whose vector differs from the entry's vector leaves remote-IRR set, so no new message follows.
- R6: An NMI (100) or INIT (101) entry with trigger bit 1 sends on every scan visit while its pin is high, with msgLevel 0. Holding the pin high for 24 clocks gives exactly 3 messages.
- R7: Messages in SMI (010), NMI (100) and ExtINT (111) modes carry vector 0. msgExtern is 1 exactly for ExtINT.
- R8: A masked entry never sends. A rising edge that arrives while the entry is masked is discarded and gives no message after unmasking.
- R9: Entries in the reserved modes 011 and 110 never produce a message.
- R10: Every message carries the entry's 3-bit mode code and destination. In fixed, lowest-priority and INIT modes it carries the programmed vector. msgLevel is 1 only for level entries in fixed or lowest-priority mode.
- R11: If a new rising edge lands in the same cycle that the scan dispatches that pin's pending edge, the new edge is kept and sent on the next pass.
- R12: A write to an entry clears that entry's pending edge and its remote-IRR bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NPINS | Interrupt input pins |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | IDX_W | Entry index to write |
| wrMode | input | 3 | Delivery mode code |
| wrLevel | input | 1 | Trigger bit, 1 = level |
| wrMask | input | 1 | Mask bit, 1 = masked |
| wrVector | input | 8 | Vector to program |
| wrDest | input | 8 | Destination to program |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | Vector being retired |
| msgValid | output | 1 | One-cycle message strobe |
| msgPin | output | IDX_W | Pin that produced the message |
| msgVector | output | 8 | Delivered vector |
| msgDest | output | 8 | Delivered destination |
| msgMode | output | 3 | Delivery mode code |
| msgLevel | output | 1 | Effective trigger mode, 1 = level |
| msgExtern | output | 1 | Vector is supplied by a legacy controller |

## Verification
The scan can dispatch a pin's pending edge in the same cycle that a fresh rising edge arrives on that pin. The pending flag's clear and set then collide. The bench first finds the scan phase from the pin's own message. It then places a second rising edge exactly eight clocks after that visit, so the edge lands on the next pass. The run passes only if two messages come out. A second collision is an end-of-interrupt racing a send, but it cannot hit a remote-IRR bit that the same cycle sets, because that bit is still clear.

// File: rtl/redirPkg.sv
package redirPkg;
  localparam int VEC_W = 8;
  localparam int DEST_W = 8;

  typedef enum logic [2:0] {
    MODE_FIXED  = 3'b000,
    MODE_LOWEST = 3'b001,
    MODE_SMI    = 3'b010,
    MODE_RSV3   = 3'b011,
    MODE_NMI    = 3'b100,
    MODE_INIT   = 3'b101,
    MODE_RSV6   = 3'b110,
    MODE_EXT    = 3'b111
  } dlvMode_e;

  typedef struct packed {
    dlvMode_e            mode;
    logic                level;
    logic                mask;
    logic [VEC_W-1:0]    vector;
    logic [DEST_W-1:0]   dest;
  } redirEntry_t;

  typedef struct packed {
    logic send;
    logic clrPend;
    logic setRirr;
    logic absorbEdge;
    logic zeroVec;
    logic extFlag;
    logic levelOut;
  } ctrlStrobe_t;

  localparam redirEntry_t RESET_ENTRY = '{mode: MODE_FIXED, level: 1'b0, mask: 1'b1,
                                         vector: '0, dest: '0};

  function automatic logic isReserved(dlvMode_e m);
    return (m == MODE_RSV3) || (m == MODE_RSV6);
  endfunction

  // fixed / lowest priority programmed for level: tracked by remote-IRR
  function automatic logic isLevelTracked(redirEntry_t e);
    return ((e.mode == MODE_FIXED) || (e.mode == MODE_LOWEST)) && e.level;
  endfunction

  // NMI / INIT programmed for level: re-sent on each visit while high
  function automatic logic isRepeat(redirEntry_t e);
    return ((e.mode == MODE_NMI) || (e.mode == MODE_INIT)) && e.level;
  endfunction

  // entry latches a pending flag on a rising pin edge
  function automatic logic edgeCaptured(redirEntry_t e);
    return !e.mask && !isReserved(e.mode) && !isLevelTracked(e);
  endfunction
endpackage

// File: rtl/redirControl.sv
module redirControl import redirPkg::*; (
  input  redirEntry_t curEntry,
  input  logic        curIrq,
  input  logic        curPend,
  input  logic        curRirr,
  output ctrlStrobe_t strb
);
  logic levelTracked;
  logic repeatCls;
  logic fireNow;

  always_comb begin
    levelTracked = isLevelTracked(curEntry);
    repeatCls    = isRepeat(curEntry);
    fireNow      = 1'b0;
    if (!curEntry.mask && !isReserved(curEntry.mode)) begin
      if (levelTracked)   fireNow = curIrq && !curRirr;
      else if (repeatCls) fireNow = curIrq || curPend;
      else                fireNow = curPend;
    end
    strb            = '0;
    strb.send       = fireNow;
    strb.clrPend    = fireNow;
    strb.setRirr    = fireNow && levelTracked;
    strb.absorbEdge = fireNow && repeatCls && curIrq;
    strb.zeroVec    = (curEntry.mode == MODE_SMI) || (curEntry.mode == MODE_NMI) ||
                      (curEntry.mode == MODE_EXT);
    strb.extFlag    = (curEntry.mode == MODE_EXT);
    strb.levelOut   = levelTracked;
  end
endmodule

// File: rtl/redirDatapath.sv
module redirDatapath import redirPkg::*; #(
  parameter  int NPINS = 8,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPINS-1:0]  irqIn,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  redirEntry_t       wrEntry,
  input  logic              eoiValid,
  input  logic [VEC_W-1:0]  eoiVector,
  input  ctrlStrobe_t       strb,
  output redirEntry_t       curEntry,
  output logic              curIrq,
  output logic              curPend,
  output logic              curRirr,
  output logic [IDX_W-1:0]  scanIdx,
  output logic              msgValid,
  output logic [IDX_W-1:0]  msgPin,
  output logic [VEC_W-1:0]  msgVector,
  output logic [DEST_W-1:0] msgDest,
  output logic [2:0]        msgMode,
  output logic              msgLevel,
  output logic              msgExtern
);
  redirEntry_t      entries [NPINS];
  logic [NPINS-1:0] pending, pendNext;
  logic [NPINS-1:0] rirr, rirrNext;
  logic [NPINS-1:0] irqPrev;

  assign curEntry = entries[scanIdx];
  assign curIrq   = irqIn[scanIdx];
  assign curPend  = pending[scanIdx];
  assign curRirr  = rirr[scanIdx];

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      pendNext[i] = pending[i];
      rirrNext[i] = rirr[i];
      if ((scanIdx == IDX_W'(i)) && strb.clrPend) pendNext[i] = 1'b0;
      // a fresh edge wins over the dispatch clear (R11)
      if (irqIn[i] && !irqPrev[i] && edgeCaptured(entries[i]) &&
          !((scanIdx == IDX_W'(i)) && strb.absorbEdge))
        pendNext[i] = 1'b1;
      if (eoiValid && (entries[i].vector == eoiVector)) rirrNext[i] = 1'b0;
      if ((scanIdx == IDX_W'(i)) && strb.setRirr) rirrNext[i] = 1'b1;
      if (wrEn && (wrIdx == IDX_W'(i))) begin
        pendNext[i] = 1'b0;
        rirrNext[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPINS; i++) entries[i] <= RESET_ENTRY;
      pending   <= '0;
      rirr      <= '0;
      irqPrev   <= '0;
      scanIdx   <= '0;
      msgValid  <= 1'b0;
      msgPin    <= '0;
      msgVector <= '0;
      msgDest   <= '0;
      msgMode   <= '0;
      msgLevel  <= 1'b0;
      msgExtern <= 1'b0;
    end else begin
      if (wrEn && (int'(wrIdx) < NPINS)) entries[wrIdx] <= wrEntry;
      pending  <= pendNext;
      rirr     <= rirrNext;
      irqPrev  <= irqIn;
      scanIdx  <= (scanIdx == IDX_W'(NPINS - 1)) ? '0 : scanIdx + 1'b1;
      msgValid <= strb.send;
      if (strb.send) begin
        msgPin    <= scanIdx;
        msgVector <= strb.zeroVec ? '0 : curEntry.vector;
        msgDest   <= curEntry.dest;
        msgMode   <= curEntry.mode;
        msgLevel  <= strb.levelOut;
        msgExtern <= strb.extFlag;
      end
    end
  end
endmodule

// File: rtl/redirScan.sv
module redirScan import redirPkg::*; #(
  parameter  int NPINS = 8,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPINS-1:0]  irqIn,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [2:0]        wrMode,
  input  logic              wrLevel,
  input  logic              wrMask,
  input  logic [VEC_W-1:0]  wrVector,
  input  logic [DEST_W-1:0] wrDest,
  input  logic              eoiValid,
  input  logic [VEC_W-1:0]  eoiVector,
  output logic              msgValid,
  output logic [IDX_W-1:0]  msgPin,
  output logic [VEC_W-1:0]  msgVector,
  output logic [DEST_W-1:0] msgDest,
  output logic [2:0]        msgMode,
  output logic              msgLevel,
  output logic              msgExtern
);
  redirEntry_t wrEntry;
  redirEntry_t curEntry;
  ctrlStrobe_t strb;
  logic        curIrq, curPend, curRirr;
  logic [IDX_W-1:0] scanIdx;

  assign wrEntry = '{mode: dlvMode_e'(wrMode), level: wrLevel, mask: wrMask,
                     vector: wrVector, dest: wrDest};

  redirControl i_ctrl (
    .curEntry(curEntry), .curIrq(curIrq), .curPend(curPend), .curRirr(curRirr),
    .strb(strb)
  );

  redirDatapath #(.NPINS(NPINS)) i_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrEntry(wrEntry),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .strb(strb),
    .curEntry(curEntry), .curIrq(curIrq), .curPend(curPend), .curRirr(curRirr),
    .scanIdx(scanIdx),
    .msgValid(msgValid), .msgPin(msgPin), .msgVector(msgVector), .msgDest(msgDest),
    .msgMode(msgMode), .msgLevel(msgLevel), .msgExtern(msgExtern)
  );
endmodule

// File: rtl/redirScanChecker.sv
module redirScanChecker #(
  parameter int IDX_W = 3,
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             msgValid,
  input logic [IDX_W-1:0] msgPin,
  input logic [7:0]       msgVector,
  input logic [2:0]       msgMode,
  input logic             msgLevel,
  input logic             msgExtern,
  input logic [IDX_W-1:0] scanIdx,
  input logic             sendStrb,
  input logic             curMask
);
  // R2
  scan_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (scanIdx == (($past(scanIdx) == IDX_W'(NPINS - 1)) ? '0 : $past(scanIdx) + 1'b1)));

  // R2
  pin_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgPin == $past(scanIdx)));

  // R7
  zero_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && (msgMode == 3'b010 || msgMode == 3'b100 || msgMode == 3'b111)) |-> (msgVector == 8'h00));

  // R7
  ext_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgExtern) |-> (msgMode == 3'b111));

  // R9
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgMode != 3'b011 && msgMode != 3'b110));

  // R10
  level_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgLevel) |-> (msgMode == 3'b000 || msgMode == 3'b001));

  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendStrb |-> !curMask);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !msgValid);
endmodule

bind redirScan redirScanChecker #(.IDX_W(IDX_W), .NPINS(NPINS)) i_redirChk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgPin(msgPin), .msgVector(msgVector),
  .msgMode(msgMode), .msgLevel(msgLevel), .msgExtern(msgExtern), .scanIdx(scanIdx),
  .sendStrb(strb.send), .curMask(curEntry.mask)
);

// File: tb/test_redirScan.sv
`timescale 1ns/1ps
module test_redirScan;
  localparam int NPINS = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NPINS-1:0] irqIn = '0;
  logic wrEn = 1'b0;
  logic [IDX_W-1:0] wrIdx = '0;
  logic [2:0] wrMode = '0;
  logic wrLevel = 1'b0, wrMask = 1'b1;
  logic [7:0] wrVector = '0, wrDest = '0;
  logic eoiValid = 1'b0;
  logic [7:0] eoiVector = '0;
  logic msgValid, msgLevel, msgExtern;
  logic [IDX_W-1:0] msgPin;
  logic [7:0] msgVector, msgDest;
  logic [2:0] msgMode;

  always #2.5 clk = ~clk;

  redirScan #(.NPINS(NPINS)) i_redirScan (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .wrIdx(wrIdx), .wrMode(wrMode),
    .wrLevel(wrLevel), .wrMask(wrMask), .wrVector(wrVector), .wrDest(wrDest),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .msgValid(msgValid), .msgPin(msgPin),
    .msgVector(msgVector), .msgDest(msgDest), .msgMode(msgMode), .msgLevel(msgLevel),
    .msgExtern(msgExtern)
  );

  int nChecks = 0, nErr = 0;
  int total = 0;
  int pinCount [NPINS];
  int lastPin = 0, lastVec = 0, lastDest = 0, lastMode = 0, lastLevel = 0, lastExt = 0;
  bit done = 1'b0;

  initial for (int i = 0; i < NPINS; i++) pinCount[i] = 0;

  // monitor samples one ns after the clock edge
  always @(posedge clk) begin
    #1;
    if (rstN && msgValid) begin
      total++;
      pinCount[msgPin]++;
      lastPin = int'(msgPin); lastVec = int'(msgVector); lastDest = int'(msgDest);
      lastMode = int'(msgMode); lastLevel = int'(msgLevel); lastExt = int'(msgExtern);
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  task automatic prog(int pin, int mode, bit lv, bit msk, int vec, int dst);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = IDX_W'(pin); wrMode = 3'(mode); wrLevel = lv; wrMask = msk;
    wrVector = 8'(vec); wrDest = 8'(dst);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic eoi(int vec);
    @(negedge clk);
    eoiValid = 1'b1; eoiVector = 8'(vec);
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    int prevPin;
    bit found;
    waitCyc(3);
    // R1: quiet after reset with all entries masked
    check("R1 msgValid during reset", int'(msgValid), 0);
    rstN = 1'b1;
    waitCyc(1);
    check("R1 msgValid after reset", int'(msgValid), 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); irqIn = (k % 2 == 0) ? '1 : '0;
    end
    irqIn = '0;
    waitCyc(16);
    check("R1 no messages while masked", total, 0);

    // Sweep: every pin, every mode code, both trigger bits (R3 R6 R7 R9 R10)
    for (int p = 0; p < NPINS; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int lv = 0; lv < 2; lv++) begin
          int vec, dst, expCnt;
          bit rsv, lt, rep;
          vec = 8'h40 + p * 8 + m + lv * 8'h80;
          dst = (p * 17 + m) ^ 8'hA5;
          rsv = (m == 3) || (m == 6);
          lt  = (m <= 1) && (lv == 1);
          rep = (m == 4 || m == 5) && (lv == 1);
          expCnt = rsv ? 0 : (rep ? 3 : 1);
          prog(p, m, lv[0], 1'b0, vec, dst);
          c0 = pinCount[p];
          irqIn[p] = 1'b1;
          waitCyc(24);
          irqIn[p] = 1'b0;
          waitCyc(16);
          if (rsv) check("R9 reserved mode sends nothing", pinCount[p] - c0, 0);
          else if (rep) check("R6 level NMI/INIT repeats", pinCount[p] - c0, expCnt);
          else if (lt) check("R4 level entry sends once", pinCount[p] - c0, expCnt);
          else check("R3 one message per edge", pinCount[p] - c0, expCnt);
          if (expCnt > 0) begin
            check("R2 msgPin", lastPin, p);
            check("R10 mode code", lastMode, m);
            check("R10 destination", lastDest, dst);
            check("R7 vector", lastVec, (m == 2 || m == 4 || m == 7) ? 0 : vec);
            check("R7 extern flag", lastExt, (m == 7) ? 1 : 0);
            check("R10 level flag", lastLevel, lt ? 1 : 0);
          end
          prog(p, 0, 1'b0, 1'b1, 0, 0);
        end
      end
    end

    // R2: all pins level NMI, messages on consecutive clocks in wrapping order
    for (int p = 0; p < NPINS; p++) prog(p, 4, 1'b1, 1'b0, p, p);
    @(negedge clk); irqIn = '1;
    waitCyc(10);
    prevPin = int'(msgPin);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check("R2 message every clock", int'(msgValid), 1);
      check("R2 scan order wraps", int'(msgPin), (prevPin + 1) % NPINS);
      prevPin = int'(msgPin);
    end
    irqIn = '0;
    for (int p = 0; p < NPINS; p++) prog(p, 0, 1'b0, 1'b1, 0, 0);
    waitCyc(16);

    // R4 / R5 / R12: level fixed entry with remote-IRR on pin 3
    prog(3, 0, 1'b1, 1'b0, 8'h33, 8'h0C);
    c0 = pinCount[3];
    irqIn[3] = 1'b1;
    waitCyc(20);
    check("R4 single send while held", pinCount[3] - c0, 1);
    eoi(8'h34);
    waitCyc(16);
    check("R5 non-matching EOI ignored", pinCount[3] - c0, 1);
    eoi(8'h33);
    waitCyc(16);
    check("R4 matching EOI re-arms", pinCount[3] - c0, 2);
    prog(3, 0, 1'b1, 1'b0, 8'h33, 8'h0C);
    waitCyc(16);
    check("R12 write clears remote-IRR", pinCount[3] - c0, 3);
    irqIn[3] = 1'b0;
    eoi(8'h33);
    waitCyc(16);
    check("R4 no send after EOI with pin low", pinCount[3] - c0, 3);
    prog(3, 0, 1'b0, 1'b1, 0, 0);

    // R8: masked entry and edge discarded while masked
    prog(5, 0, 1'b0, 1'b1, 8'h55, 8'h05);
    c0 = pinCount[5];
    @(negedge clk); irqIn[5] = 1'b1;
    @(negedge clk); irqIn[5] = 1'b0;
    waitCyc(16);
    check("R8 masked edge gives nothing", pinCount[5] - c0, 0);
    prog(5, 0, 1'b1, 1'b1, 8'h55, 8'h05);
    @(negedge clk); irqIn[5] = 1'b1;
    waitCyc(20);
    irqIn[5] = 1'b0;
    check("R8 masked level gives nothing", pinCount[5] - c0, 0);
    prog(5, 0, 1'b0, 1'b0, 8'h55, 8'h05);
    waitCyc(16);
    check("R8 discarded edge stays lost", pinCount[5] - c0, 0);
    prog(5, 0, 1'b0, 1'b1, 0, 0);

    // R12: pending edge cleared by a write before dispatch is hard to time; checked via R11 setup
    // R11: new edge on the dispatch cycle of the same pin
    prog(0, 0, 1'b0, 1'b0, 8'h10, 8'h01);
    @(negedge clk); irqIn[0] = 1'b1;
    @(negedge clk); irqIn[0] = 1'b0;
    found = 1'b0;
    for (int k = 0; k < 20 && !found; k++) begin
      @(negedge clk);
      if (msgValid && msgPin == 0) found = 1'b1;
    end
    check("R11 phase found", int'(found), 1);
    c0 = pinCount[0];
    waitCyc(2); irqIn[0] = 1'b1;
    waitCyc(1); irqIn[0] = 1'b0;
    waitCyc(4); irqIn[0] = 1'b1;
    waitCyc(1); irqIn[0] = 1'b0;
    waitCyc(24);
    check("R11 colliding edge kept", pinCount[0] - c0, 2);
    prog(0, 0, 1'b0, 1'b1, 0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule